// File: doc/BRIEF.md
# Slave-Mode Array Programming Controller

This block lets an external master program and read back a word-wide nonvolatile array over a shared 16-bit parallel port. It uses three active-low strobes. The command strobe loads a command word: a word address plus a mode bit. The data strobe either supplies one word to program or asks for one word to be read back onto the port. The step strobe moves the stored address to the next word, so sequential locations need no new command. All three strobes pass through synchronizers, so every edge takes effect a fixed number of cycles after it reaches the pins.

A program operation writes the word into the array and reads it back at once. The controller then compares the two values. The result of the last comparison appears on `pass_last`. `pass_all` stays high only while every comparison since reset has matched. The master must respect minimum spacing between strobes and a start-up delay after reset. Any strobe edge that breaks a timing rule, or that arrives with no valid command, is dropped and sets a sticky protocol error.

The array side is a request stream with valid/ready flow control. A request (`mem_valid` with `mem_write`, `mem_addr`, `mem_wdata`) stays frozen until the cycle in which `mem_ready` is high, and it is taken in that cycle. Read data returns later, in any cycle, marked by `mem_rvalid`. Only one request is ever outstanding. The array may stall for any number of cycles, and the controller simply waits.

Top module: `nvm_slave_prog`

## Requirements
- R1: While reset is held and just after it, `bus_oe`, `pass_last`, `proto_err` and `mem_valid` are 0 and `pass_all` is 1.
- R2: A falling command strobe seen fewer than RESET_HOLD cycles after reset release is ignored and sets `proto_err`.
- R3: The command word carries the mode in `bus_in[0]` (1 = program, 0 = read-back) and the word address in `bus_in[ADDR_W:1]`. The command is adopted at the rising command strobe only if the strobe stayed low for at least PALE_MIN cycles. A shorter pulse discards the command, leaves no valid address, and sets `proto_err`.
- R4: In program mode, a falling data strobe captures `bus_in`, writes it to the current address, and reads that address back. `pass_last` becomes 1 if the read-back equals the captured word and 0 if it does not.
- R5: A read-back mismatch clears `pass_all`, which stays 0 until reset, even after later matches.
- R6: In read-back mode, a falling data strobe reads the current address. The word is driven on `bus_out`, with `bus_oe` high, no sooner than DUMP_DLY cycles after the edge is accepted. It is held until the data strobe rises, and the array stays idle while it is driven.
- R7: A falling step strobe, accepted while the data strobe is high, adds one to the stored word address. The address wraps from 2^ADDR_W-1 to 0.
- R8: A falling command or data strobe seen fewer than GAP cycles after the data strobe rose, or a falling data strobe seen fewer than GAP cycles after the command strobe rose, is ignored and sets `proto_err`.
- R9: `proto_err` is sticky until reset. A falling data strobe with no valid command is ignored and sets it.
- R10: A request on the array side keeps `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` unchanged until it is taken with `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is the unit of all timing rules |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_stb_n | input | 1 | Command strobe, active low |
| data_stb_n | input | 1 | Data strobe, active low |
| step_n | input | 1 | Address step strobe, active low |
| bus_in | input | DATA_W | Port value driven by the master |
| bus_out | output | DATA_W | Read-back word driven to the master |
| bus_oe | output | 1 | High while `bus_out` is being driven |
| mem_valid | output | 1 | Array request valid |
| mem_ready | input | 1 | Array accepts the request |
| mem_write | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Array word address |
| mem_wdata | output | DATA_W | Array write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| pass_last | output | 1 | Last program operation verified |
| pass_all | output | 1 | Every program operation since reset verified |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The bench builds the block with ADDR_W=6, RESET_HOLD=40, GAP=12, PALE_MIN=4 and DUMP_DLY=3. With these values the address wrap, the start-up hold window and every spacing violation can be reached in a few hundred cycles. A 64-word array model with one corrupting location forces a read-back mismatch. Random stalls on `mem_ready` exercise the request hold rule.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RB_REQ,
    ST_RB_WAIT,
    ST_DMP_REQ,
    ST_DMP_WAIT,
    ST_DMP_DRV
  } eng_state_t;

  typedef enum logic {
    MODE_DUMP = 1'b0,
    MODE_PROG = 1'b1
  } cmd_mode_t;

  // strobe lanes inside the synchronizer vector
  localparam int unsigned STB_ADDR  = 0;
  localparam int unsigned STB_DATA  = 1;
  localparam int unsigned STB_STEP  = 2;
  localparam int unsigned STB_COUNT = 3;

endpackage

// File: rtl/nvm_strobe_sync.sv
module nvm_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic level,
  output logic edge_seen
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], strobe_n};
  end

  assign level     = chain[STAGES-1];
  assign edge_seen = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/nvm_sat_timer.sv
module nvm_sat_timer #(
  parameter int LIMIT      = 16,
  parameter bit START_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= START_FULL ? TOP : '0;
    else if (restart)    cnt <= CW'(1);
    else if (cnt != TOP) cnt <= cnt + CW'(1);
  end

  assign done = (cnt == TOP);

endmodule

// File: rtl/nvm_gap_guard.sv
module nvm_gap_guard #(
  parameter int RESET_HOLD = 1100,
  parameter int GAP        = 220,
  parameter int PALE_MIN   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_rise,
  input  logic addr_rise,
  input  logic addr_start,
  output logic hold_done,
  output logic data_gap_ok,
  output logic addr_gap_ok,
  output logic width_ok
);

  nvm_sat_timer #(.LIMIT(RESET_HOLD), .START_FULL(1'b0)) u_hold (
    .clk(clk), .rst_n(rst_n), .restart(1'b0), .done(hold_done));

  nvm_sat_timer #(.LIMIT(GAP), .START_FULL(1'b1)) u_data_gap (
    .clk(clk), .rst_n(rst_n), .restart(data_rise), .done(data_gap_ok));

  nvm_sat_timer #(.LIMIT(GAP), .START_FULL(1'b1)) u_addr_gap (
    .clk(clk), .rst_n(rst_n), .restart(addr_rise), .done(addr_gap_ok));

  nvm_sat_timer #(.LIMIT(PALE_MIN), .START_FULL(1'b0)) u_width (
    .clk(clk), .rst_n(rst_n), .restart(addr_start), .done(width_ok));

endmodule

// File: rtl/nvm_prog_engine.sv
module nvm_prog_engine
  import nvm_prog_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 16,
  parameter int DUMP_DLY = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    bus_in,
  input  logic [STB_COUNT-1:0] stb_level,
  input  logic [STB_COUNT-1:0] stb_edge,
  input  logic                 hold_done,
  input  logic                 data_gap_ok,
  input  logic                 addr_gap_ok,
  input  logic                 width_ok,
  output logic                 addr_start,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic                 mem_ready,
  input  logic                 mem_rvalid,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [DATA_W-1:0]    bus_out,
  output logic                 bus_oe,
  output logic                 pass_last,
  output logic                 pass_all,
  output logic                 proto_err
);

  localparam int DLY_W = $clog2(DUMP_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_TOP = DLY_W'(DUMP_DLY);

  eng_state_t        state_q;
  cmd_mode_t         mode_q, pend_mode_q;
  logic [ADDR_W-1:0] addr_q, pend_addr_q;
  logic [DATA_W-1:0] data_q, dout_q;
  logic [DLY_W-1:0]  dly_q;
  logic              addr_valid_q, pend_q, got_q;
  logic              pass_last_q, pass_all_q, err_q;

  logic addr_fall, addr_rise, data_fall, data_rise, step_fall;
  logic busy, addr_ok, data_ok, step_ok, commit, bad;

  assign addr_fall = stb_edge[STB_ADDR] & ~stb_level[STB_ADDR];
  assign addr_rise = stb_edge[STB_ADDR] &  stb_level[STB_ADDR];
  assign data_fall = stb_edge[STB_DATA] & ~stb_level[STB_DATA];
  assign data_rise = stb_edge[STB_DATA] &  stb_level[STB_DATA];
  assign step_fall = stb_edge[STB_STEP] & ~stb_level[STB_STEP];

  assign busy    = (state_q != ST_IDLE);
  assign addr_ok = addr_fall & hold_done & data_gap_ok & ~busy;
  assign data_ok = data_fall & addr_valid_q & ~pend_q & ~busy
                 & stb_level[STB_ADDR] & stb_level[STB_STEP]
                 & data_gap_ok & addr_gap_ok;
  assign step_ok = step_fall & addr_valid_q & ~pend_q & ~busy & stb_level[STB_DATA];
  assign commit  = addr_rise & pend_q;
  assign bad     = (addr_fall & ~addr_ok) | (data_fall & ~data_ok)
                 | (step_fall & ~step_ok) | (commit & ~width_ok);

  assign addr_start = addr_ok;

  // command capture, commit and stepping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
      pend_mode_q  <= MODE_DUMP;
      addr_q       <= '0;
      mode_q       <= MODE_DUMP;
      addr_valid_q <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      err_q <= err_q | bad;
      if (addr_ok) begin
        pend_q       <= 1'b1;
        pend_addr_q  <= bus_in[ADDR_W:1];
        pend_mode_q  <= cmd_mode_t'(bus_in[0]);
        addr_valid_q <= 1'b0;
      end else if (commit) begin
        pend_q <= 1'b0;
        if (width_ok) begin
          addr_q       <= pend_addr_q;
          mode_q       <= pend_mode_q;
          addr_valid_q <= 1'b1;
        end
      end else if (step_ok) begin
        addr_q <= addr_q + ADDR_W'(1);
      end
    end
  end

  // array sequencing and verification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      data_q      <= '0;
      dout_q      <= '0;
      dly_q       <= '0;
      got_q       <= 1'b0;
      pass_last_q <= 1'b0;
      pass_all_q  <= 1'b1;
    end else begin
      if (state_q inside {ST_DMP_REQ, ST_DMP_WAIT} && dly_q != DLY_TOP)
        dly_q <= dly_q + DLY_W'(1);
      unique case (state_q)
        ST_IDLE: begin
          if (data_ok) begin
            dly_q <= '0;
            got_q <= 1'b0;
            if (mode_q == MODE_PROG) begin
              data_q      <= bus_in;
              pass_last_q <= 1'b0;
              state_q     <= ST_WR;
            end else begin
              state_q <= ST_DMP_REQ;
            end
          end
        end
        ST_WR:     if (mem_ready) state_q <= ST_RB_REQ;
        ST_RB_REQ: if (mem_ready) state_q <= ST_RB_WAIT;
        ST_RB_WAIT: begin
          if (mem_rvalid) begin
            pass_last_q <= (mem_rdata == data_q);
            if (mem_rdata != data_q) pass_all_q <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_DMP_REQ: if (mem_ready) state_q <= ST_DMP_WAIT;
        ST_DMP_WAIT: begin
          if (mem_rvalid) begin
            dout_q <= mem_rdata;
            got_q  <= 1'b1;
          end
          if (got_q && dly_q == DLY_TOP)
            state_q <= stb_level[STB_DATA] ? ST_IDLE : ST_DMP_DRV;
        end
        ST_DMP_DRV: if (data_rise) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = state_q inside {ST_WR, ST_RB_REQ, ST_DMP_REQ};
  assign mem_write = (state_q == ST_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign bus_oe    = (state_q == ST_DMP_DRV);
  assign bus_out   = bus_oe ? dout_q : '0;
  assign pass_last = pass_last_q;
  assign pass_all  = pass_all_q;
  assign proto_err = err_q;

endmodule

// File: rtl/nvm_slave_prog.sv
module nvm_slave_prog
  import nvm_prog_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_HOLD  = 1100,
  parameter int GAP         = 220,
  parameter int PALE_MIN    = 50,
  parameter int DUMP_DLY    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb_n,
  input  logic              data_stb_n,
  input  logic              step_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pass_last,
  output logic              pass_all,
  output logic              proto_err
);

  logic [STB_COUNT-1:0] raw, lvl, edg;
  logic hold_done, data_gap_ok, addr_gap_ok, width_ok, addr_start;

  always_comb begin
    raw           = '1;
    raw[STB_ADDR] = addr_stb_n;
    raw[STB_DATA] = data_stb_n;
    raw[STB_STEP] = step_n;
  end

  for (genvar i = 0; i < STB_COUNT; i++) begin : g_sync
    nvm_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(raw[i]),
      .level(lvl[i]), .edge_seen(edg[i]));
  end

  nvm_gap_guard #(
    .RESET_HOLD(RESET_HOLD), .GAP(GAP), .PALE_MIN(PALE_MIN)
  ) u_guard (
    .clk(clk), .rst_n(rst_n),
    .data_rise(edg[STB_DATA] & lvl[STB_DATA]),
    .addr_rise(edg[STB_ADDR] & lvl[STB_ADDR]),
    .addr_start(addr_start),
    .hold_done(hold_done), .data_gap_ok(data_gap_ok),
    .addr_gap_ok(addr_gap_ok), .width_ok(width_ok));

  nvm_prog_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUMP_DLY(DUMP_DLY)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .stb_level(lvl), .stb_edge(edg),
    .hold_done(hold_done), .data_gap_ok(data_gap_ok),
    .addr_gap_ok(addr_gap_ok), .width_ok(width_ok),
    .addr_start(addr_start),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .bus_out(bus_out), .bus_oe(bus_oe),
    .pass_last(pass_last), .pass_all(pass_all), .proto_err(proto_err));

endmodule

// File: rtl/nvm_prog_chk.sv
module nvm_prog_chk #(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          bus_oe,
  input logic          pass_last,
  input logic          pass_all,
  input logic          proto_err
);

  // R5
  pass_all_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pass_all));

  // R5
  mismatch_clears_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_all) |-> !pass_last);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(proto_err));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write)
      && $stable(mem_addr) && $stable(mem_wdata));

  // R6
  drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !mem_valid);

endmodule

bind nvm_slave_prog nvm_prog_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .bus_oe(bus_oe), .pass_last(pass_last), .pass_all(pass_all),
  .proto_err(proto_err));

// File: tb/nvm_slave_prog_test.sv
module nvm_slave_prog_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int HOLD  = 40;
  localparam int GAP   = 12;
  localparam int PMIN  = 4;
  localparam int DDLY  = 3;
  localparam int FAULT = 13;
  localparam logic [DW-1:0] FLIP = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_stb_n = 1'b1, data_stb_n = 1'b1, step_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out, mem_wdata, mem_rdata;
  logic bus_oe, mem_valid, mem_write, mem_rvalid, pass_last, pass_all, proto_err;
  logic mem_ready;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;
  logic [DW-1:0] arr [1<<AW];
  logic [DW-1:0] exp_arr [1<<AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_slave_prog #(
    .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .RESET_HOLD(HOLD),
    .GAP(GAP), .PALE_MIN(PMIN), .DUMP_DLY(DDLY)
  ) uut (
    .clk(clk), .rst_n(rst_n), .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
    .step_n(step_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .pass_last(pass_last), .pass_all(pass_all),
    .proto_err(proto_err));

  // array model: one location corrupts a bit on write; random stalls (R10)
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_write) arr[mem_addr] <= (int'(mem_addr) == FAULT) ? (mem_wdata ^ FLIP) : mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= arr[mem_addr];
      end
    end
    mem_ready <= ($urandom % 4) != 0;
  end

  function automatic logic [DW-1:0] stored(input int a, input logic [DW-1:0] d);
    return (a == FAULT) ? (d ^ FLIP) : d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; addr_stb_n = 1'b1; data_stb_n = 1'b1; step_n = 1'b1;
    cyc(4);
    rst_n = 1'b1;
  endtask

  task automatic send_cmd(input int a, input bit prog, input int width);
    bus_in = (DW'(a) << 1) | DW'(prog);
    addr_stb_n = 1'b0;
    cyc(width);
    addr_stb_n = 1'b1;
    cyc(GAP + 4);
  endtask

  task automatic prog_word(input logic [DW-1:0] d);
    bus_in = d;
    data_stb_n = 1'b0;
    cyc(40);
    data_stb_n = 1'b1;
    cyc(GAP + 4);
  endtask

  task automatic dump_word(input string tag, input logic [DW-1:0] exp);
    bus_in = '0;
    data_stb_n = 1'b0;
    cyc(2);
    chk({tag, " R6 early oe"}, 32'(bus_oe), 32'd0);
    cyc(38);
    chk({tag, " R6 oe"}, 32'(bus_oe), 32'd1);
    chk({tag, " R6 data"}, 32'(bus_out), 32'(exp));
    data_stb_n = 1'b1;
    cyc(5);
    chk({tag, " R6 release"}, 32'(bus_oe), 32'd0);
    cyc(GAP);
  endtask

  task automatic step();
    step_n = 1'b0;
    cyc(3);
    step_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(2);
    // R1 reset state
    chk("R1 oe", 32'(bus_oe), 0);
    chk("R1 pass_last", 32'(pass_last), 0);
    chk("R1 pass_all", 32'(pass_all), 1);
    chk("R1 err", 32'(proto_err), 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
    rst_n = 1'b1;
    // R2 command inside the start-up hold is refused
    cyc(2);
    send_cmd(3, 1'b1, PMIN + 3);
    chk("R2 early cmd err", 32'(proto_err), 1);
    do_reset();
    cyc(HOLD + 4);
    chk("R1 err after reset", 32'(proto_err), 0);

    // R4 directed program
    send_cmd(5, 1'b1, PMIN + 3);
    prog_word(16'hA5A5); exp_arr[5] = 16'hA5A5;
    chk("R4 pass_last", 32'(pass_last), 1);
    chk("R4 pass_all", 32'(pass_all), 1);
    // R7 step then program next word
    step();
    prog_word(16'h1234); exp_arr[6] = 16'h1234;
    chk("R7 step pass", 32'(pass_last), 1);
    // R7 wrap at top of address space
    send_cmd(63, 1'b1, PMIN + 3);
    prog_word(16'h0F0F); exp_arr[63] = 16'h0F0F;
    step();
    prog_word(16'h7E57); exp_arr[0] = 16'h7E57;

    // R4 random programs
    for (int i = 0; i < 12; i++) begin
      int a;
      logic [DW-1:0] d;
      a = ($urandom % 48) + 7;
      if (a == FAULT) a = 14;
      d = DW'($urandom);
      send_cmd(a, 1'b1, PMIN + 3);
      prog_word(d);
      exp_arr[a] = stored(a, d);
      chk("R4 random pass", 32'(pass_last), 1);
    end

    // R6 read-back, R7 wrap seen through read-back
    send_cmd(5, 1'b0, PMIN + 3);
    dump_word("R6 addr5", exp_arr[5]);
    step();
    dump_word("R7 addr6", exp_arr[6]);
    send_cmd(63, 1'b0, PMIN + 3);
    step();
    dump_word("R7 wrap addr0", exp_arr[0]);
    chk("R9 no err so far", 32'(proto_err), 0);

    // R5 failing location, then a later match
    send_cmd(FAULT, 1'b1, PMIN + 3);
    prog_word(16'h5555); exp_arr[FAULT] = stored(FAULT, 16'h5555);
    chk("R5 fail last", 32'(pass_last), 0);
    chk("R5 fail all", 32'(pass_all), 0);
    send_cmd(20, 1'b1, PMIN + 3);
    prog_word(16'h2020); exp_arr[20] = 16'h2020;
    chk("R5 later pass_last", 32'(pass_last), 1);
    chk("R5 pass_all stays low", 32'(pass_all), 0);

    // R3 short command pulse discarded, data strobe then refused (R9)
    do_reset(); cyc(HOLD + 4);
    chk("R5 pass_all after reset", 32'(pass_all), 1);
    send_cmd(20, 1'b0, 1);
    chk("R3 short pulse err", 32'(proto_err), 1);
    data_stb_n = 1'b0;
    cyc(30);
    chk("R9 no-command oe", 32'(bus_oe), 0);
    data_stb_n = 1'b1;
    cyc(GAP + 4);
    chk("R9 err sticky", 32'(proto_err), 1);

    // R9 data strobe with no command after reset
    do_reset(); cyc(HOLD + 4);
    bus_in = '0;
    data_stb_n = 1'b0; cyc(30); data_stb_n = 1'b1; cyc(GAP + 4);
    chk("R9 no command err", 32'(proto_err), 1);

    // R8 command too soon after data strobe rises: address unchanged
    do_reset(); cyc(HOLD + 4);
    send_cmd(5, 1'b0, PMIN + 3);
    data_stb_n = 1'b0; cyc(40); data_stb_n = 1'b1;
    cyc(2);
    send_cmd(6, 1'b0, PMIN + 3);
    chk("R8 early cmd err", 32'(proto_err), 1);
    dump_word("R8 addr kept", exp_arr[5]);

    // R8 data strobe too soon after command strobe rises
    do_reset(); cyc(HOLD + 4);
    bus_in = (DW'(20) << 1);
    addr_stb_n = 1'b0; cyc(PMIN + 3); addr_stb_n = 1'b1;
    cyc(2);
    data_stb_n = 1'b0; cyc(30);
    chk("R8 early data oe", 32'(bus_oe), 0);
    chk("R8 early data err", 32'(proto_err), 1);
    data_stb_n = 1'b1;
    cyc(GAP + 4);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule